// File: doc/BRIEF.md
# Clock Frequency Lock Detector

This block judges whether a feedback clock runs at the same frequency as a reference clock. Both clocks are derived inside the block. A raw reference source clock is divided by a programmable integer to give the reference clock. A fast oscillator clock is divided by a second programmable integer to give the feedback clock. The detector compares frequency only and never looks at phase. It counts feedback periods over a measurement window of a fixed number of reference clock periods. A slower reference clock therefore gives a slower verdict.

The verdict is a lock status with hysteresis. Lock is acquired only when a window count lands close to the expected value. Once held, lock is dropped only when a count strays beyond a wider band. Every change of the lock status, up or down, sets a sticky change flag. Software clears that flag by writing one. An interrupt request is the flag gated by an enable. With the enable off, software can still poll the status pin.

The divider settings are plain control inputs and are expected to stay static between changes. Any change to either divider restarts the measurement. There is no streaming data path, so every pin is a plain control or status signal. Correct counting needs the feedback clock to stay slower than half the reference source clock, which holds whenever the reference divider is at least 1 and the loop is near lock.

Top module: `lockdet`

## Requirements
- R1: While reset is asserted and just after it is released, `lock`, `lock_chg_flag` and `lock_irq` are 0.
- R2: The reference clock period is (`ref_div`+1) source clock periods, and the feedback period is (`syn_div`+1) oscillator periods. A measurement window lasts 64 reference periods, so a verdict appears every 64·(`ref_div`+1) source clock cycles.
- R3: While unlocked, `lock` goes to 1 at the end of a compared window whose feedback count lies within 63..65.
- R4: Hysteresis. While locked, a count within 61..67 keeps `lock` at 1. While unlocked, a count of 66 or 67 (or 61, 62) does not set `lock`.
- R5: While locked, a window count below 61 or above 67 clears `lock` at the end of that window.
- R6: After reset, and on any change of `ref_div` or `syn_div`, `lock` is forced to 0 within one cycle. The measurement window restarts, and the first complete window after that is discarded without a verdict.
- R7: `lock_chg_flag` is set in the cycle `lock` changes, in either direction. It stays set until a `lock_irq_clr` pulse clears it. A new change in the same cycle as a clear wins.
- R8: `lock_irq` is `lock_chg_flag` AND `lock_ie`. `lock_ie` has no effect on the flag itself.
- R9: `lock` changes only at a window end or on a forced clear from R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_src | input | 1 | Raw reference source clock; all judging and status logic runs on it |
| clk_osc | input | 1 | Fast oscillator clock to be divided into the feedback clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_div | input | 4 | Reference divider setting; divide ratio is value+1 |
| syn_div | input | 6 | Feedback divider setting; divide ratio is value+1 |
| lock_ie | input | 1 | Enables the interrupt request |
| lock_irq_clr | input | 1 | Write-one-to-clear pulse for the change flag |
| lock | output | 1 | Read-only lock status |
| lock_chg_flag | output | 1 | Sticky flag set on every lock change |
| lock_irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the hysteresis band, where a window count sits two or three away from the expected value. The same frequency must then hold lock when already locked and refuse lock when unlocked. The bench reaches that band by scaling the oscillator half-period by a few percent, so each window yields 66 or 67 feedback periods. It enters the band once from the locked state and once from a fresh, unlocked state forced by a divider change. A scoreboard queue records every expected lock transition, so a spurious flip anywhere in the run is caught. The window length itself is pinned by sampling just before and just after the second window end with a large reference divider.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;

  // Judge phase: the first window after a restart only primes the counters.
  typedef enum logic {
    JM_DISCARD = 1'b0,
    JM_COMPARE = 1'b1
  } judge_mode_e;

  // Two-stage synchroniser depth used for the feedback toggle.
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/lockdet_fb_div.sv
`timescale 1ns/1ps
// Oscillator-domain divider. Toggles fb_tgl once per feedback period,
// i.e. once every (div+1) oscillator cycles.
module lockdet_fb_div #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             fb_tgl
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      fb_tgl <= 1'b0;
    end else if (cnt >= div) begin
      // >= so a setting lowered mid-count still wraps at once
      cnt    <= '0;
      fb_tgl <= ~fb_tgl;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lockdet_edge_sync.sv
`timescale 1ns/1ps
// Brings a slow toggle into the local domain and emits one pulse per toggle.
module lockdet_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_tgl,
  output logic pulse
);

  // [STAGES-1:0] are metastability stages, [STAGES] holds the prior value.
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_tgl};
  end

  assign pulse = shreg[STAGES] ^ shreg[STAGES-1];

endmodule

// File: rtl/lockdet_window.sv
`timescale 1ns/1ps
// Reference divider plus window timer plus saturating feedback counter.
module lockdet_window #(
  parameter int unsigned REF_DIV_W = 4,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic [REF_DIV_W-1:0] ref_div,
  input  logic                 fb_pulse,
  output logic                 win_end,
  output logic [CNT_W-1:0]     win_count
);

  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  logic [REF_DIV_W-1:0] ref_cnt;
  logic                 ref_tick;
  logic [WIN_W-1:0]     win_cnt;
  logic [CNT_W-1:0]     fb_cnt;
  logic [CNT_W-1:0]     fb_inc;

  assign ref_tick = (ref_cnt >= ref_div);
  assign win_end  = ref_tick && (win_cnt == WIN_LAST) && !restart;
  assign fb_inc   = (fb_pulse && (fb_cnt != '1)) ? fb_cnt + 1'b1 : fb_cnt;
  assign win_count = fb_inc;   // includes a pulse landing on the last cycle

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      win_cnt <= '0;
      fb_cnt  <= '0;
    end else if (restart) begin
      ref_cnt <= '0;
      win_cnt <= '0;
      fb_cnt  <= '0;
    end else begin
      ref_cnt <= ref_tick ? '0 : ref_cnt + 1'b1;
      if (ref_tick) win_cnt <= (win_cnt == WIN_LAST) ? '0 : win_cnt + 1'b1;
      fb_cnt  <= win_end ? '0 : fb_inc;
    end
  end

endmodule

// File: rtl/lockdet_judge.sv
`timescale 1ns/1ps
// Hysteresis decision at each window end.
module lockdet_judge
  import lockdet_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned WIN_LEN    = 64,
  parameter int unsigned LOCK_TOL   = 1,
  parameter int unsigned UNLOCK_TOL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             win_end,
  input  logic [CNT_W-1:0] win_count,
  output logic             lock,
  output logic             lock_nxt
);

  localparam logic [CNT_W-1:0] EXPECT = CNT_W'(WIN_LEN);

  judge_mode_e      mode;
  logic [CNT_W-1:0] err;
  logic             near;
  logic             far;

  assign err  = (win_count >= EXPECT) ? win_count - EXPECT : EXPECT - win_count;
  assign near = (err <= CNT_W'(LOCK_TOL));
  assign far  = (err >  CNT_W'(UNLOCK_TOL));

  always_comb begin
    lock_nxt = lock;
    if (restart) begin
      lock_nxt = 1'b0;
    end else if (win_end && (mode == JM_COMPARE)) begin
      if (lock && far)        lock_nxt = 1'b0;
      else if (!lock && near) lock_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      mode <= JM_DISCARD;
    end else begin
      lock <= lock_nxt;
      if (restart)      mode <= JM_DISCARD;
      else if (win_end) mode <= JM_COMPARE;
    end
  end

endmodule

// File: rtl/lockdet.sv
`timescale 1ns/1ps
// Frequency lock detector top.
module lockdet #(
  parameter int unsigned REF_DIV_W  = 4,
  parameter int unsigned SYN_DIV_W  = 6,
  parameter int unsigned WIN_LEN    = 64,
  parameter int unsigned LOCK_TOL   = 1,
  parameter int unsigned UNLOCK_TOL = 3
) (
  input  logic                 clk_ref_src,
  input  logic                 clk_osc,
  input  logic                 rst_n,
  input  logic [REF_DIV_W-1:0] ref_div,
  input  logic [SYN_DIV_W-1:0] syn_div,
  input  logic                 lock_ie,
  input  logic                 lock_irq_clr,
  output logic                 lock,
  output logic                 lock_chg_flag,
  output logic                 lock_irq
);

  // Room for twice the expected count before saturation.
  localparam int unsigned CNT_W = $clog2(WIN_LEN) + 2;

  logic                 fb_tgl;
  logic                 fb_pulse;
  logic                 win_end;
  logic [CNT_W-1:0]     win_count;
  logic                 lock_nxt;
  logic                 cfg_chg;
  logic [REF_DIV_W-1:0] ref_div_q;
  logic [SYN_DIV_W-1:0] syn_div_q;

  // Divider settings are quasi-static; a change restarts measurement.
  assign cfg_chg = (ref_div != ref_div_q) || (syn_div != syn_div_q);

  always_ff @(posedge clk_ref_src or negedge rst_n) begin
    if (!rst_n) begin
      ref_div_q <= '0;
      syn_div_q <= '0;
    end else begin
      ref_div_q <= ref_div;
      syn_div_q <= syn_div;
    end
  end

  lockdet_fb_div #(.DIV_W(SYN_DIV_W)) u_fb_div (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .div    (syn_div),
    .fb_tgl (fb_tgl)
  );

  lockdet_edge_sync #(.STAGES(lockdet_pkg::SYNC_STAGES)) u_sync (
    .clk       (clk_ref_src),
    .rst_n     (rst_n),
    .async_tgl (fb_tgl),
    .pulse     (fb_pulse)
  );

  lockdet_window #(
    .REF_DIV_W (REF_DIV_W),
    .WIN_LEN   (WIN_LEN),
    .CNT_W     (CNT_W)
  ) u_window (
    .clk       (clk_ref_src),
    .rst_n     (rst_n),
    .restart   (cfg_chg),
    .ref_div   (ref_div),
    .fb_pulse  (fb_pulse),
    .win_end   (win_end),
    .win_count (win_count)
  );

  lockdet_judge #(
    .CNT_W      (CNT_W),
    .WIN_LEN    (WIN_LEN),
    .LOCK_TOL   (LOCK_TOL),
    .UNLOCK_TOL (UNLOCK_TOL)
  ) u_judge (
    .clk       (clk_ref_src),
    .rst_n     (rst_n),
    .restart   (cfg_chg),
    .win_end   (win_end),
    .win_count (win_count),
    .lock      (lock),
    .lock_nxt  (lock_nxt)
  );

  // Sticky change flag; a fresh change beats a clear in the same cycle.
  always_ff @(posedge clk_ref_src or negedge rst_n) begin
    if (!rst_n)                lock_chg_flag <= 1'b0;
    else if (lock_nxt != lock) lock_chg_flag <= 1'b1;
    else if (lock_irq_clr)     lock_chg_flag <= 1'b0;
  end

  assign lock_irq = lock_chg_flag & lock_ie;

endmodule

// File: rtl/lockdet_sva.sv
`timescale 1ns/1ps
module lockdet_sva (
  input logic clk,
  input logic rst_n,
  input logic lock,
  input logic flag,
  input logic irq_clr,
  input logic win_end,
  input logic cfg_chg
);

  // R7: a lock change is always recorded in the flag
  assert_flag_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock) |-> flag);

  // R7: without a clear the flag stays set
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !irq_clr) |=> flag);

  // R9: lock moves only at a window end or a forced restart
  assert_lock_moves_at_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock) |-> ($past(win_end) || $past(cfg_chg)));

  // R6: a divider change drops lock on the next cycle
  assert_cfg_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !lock);

  // R6: no window end can be reported in the restart cycle
  assert_no_end_on_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |-> !win_end);

endmodule

bind lockdet lockdet_sva u_lockdet_sva (
  .clk     (clk_ref_src),
  .rst_n   (rst_n),
  .lock    (lock),
  .flag    (lock_chg_flag),
  .irq_clr (lock_irq_clr),
  .win_end (win_end),
  .cfg_chg (cfg_chg)
);

// File: tb/tb_lockdet.sv
`timescale 1ns/1ps
module tb_lockdet;

  logic       clk_ref_src = 1'b0;
  logic       clk_osc     = 1'b0;
  logic       rst_n       = 1'b0;
  logic [3:0] ref_div     = 4'd3;
  logic [5:0] syn_div     = 6'd9;
  logic       lock_ie     = 1'b0;
  logic       lock_irq_clr = 1'b0;
  logic       lock;
  logic       lock_chg_flag;
  logic       lock_irq;

  realtime osc_half = 2.0;
  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  exp_q[$];
  logic lock_prev = 1'b0;

  always #5 clk_ref_src = ~clk_ref_src;        // 100 MHz
  always #(osc_half) clk_osc = ~clk_osc;

  lockdet dut (
    .clk_ref_src  (clk_ref_src),
    .clk_osc      (clk_osc),
    .rst_n        (rst_n),
    .ref_div      (ref_div),
    .syn_div      (syn_div),
    .lock_ie      (lock_ie),
    .lock_irq_clr (lock_irq_clr),
    .lock         (lock),
    .lock_chg_flag(lock_chg_flag),
    .lock_irq     (lock_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_lock(input bit v);
    exp_q.push_back(v);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_ref_src);
  endtask

  function automatic int win_cyc();
    return 64 * (int'(ref_div) + 1);
  endfunction

  task automatic wins(input int n);
    cycles(n * win_cyc());
  endtask

  task automatic clear_flag();
    lock_irq_clr = 1'b1;
    cycles(1);
    lock_irq_clr = 1'b0;
    cycles(1);
  endtask

  // Scoreboard monitor: every lock transition must match the next queued one (R3, R5)
  always @(negedge clk_ref_src) begin
    if (rst_n && (lock !== lock_prev)) begin
      bit e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R5 unexpected transition: actual %0d expected %0d at %0t",
                 lock, lock_prev, $time);
      end else begin
        e = exp_q.pop_front();
        if (lock !== e) begin
          errors++;
          $display("FAIL R3/R5 transition: actual %0d expected %0d at %0t", lock, e, $time);
        end
      end
      lock_prev = lock;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(5);
    chk("R1 lock in reset", lock, 0);
    chk("R1 flag in reset", lock_chg_flag, 0);
    chk("R1 irq in reset", lock_irq, 0);
    rst_n = 1'b1;
    cycles(1);
    chk("R1 lock after reset", lock, 0);

    // Matched: ref 40 ns, feedback 10*4 ns = 40 ns, count 64
    expect_lock(1);
    cycles(win_cyc() * 3 / 2);
    chk("R6 first window discarded", lock, 0);
    cycles(win_cyc());
    chk("R3 lock acquired", lock, 1);
    chk("R7 flag on rise", lock_chg_flag, 1);
    chk("R8 irq masked", lock_irq, 0);
    lock_ie = 1'b1;
    cycles(1);
    chk("R8 irq enabled", lock_irq, 1);
    clear_flag();
    chk("R7 flag cleared", lock_chg_flag, 0);
    chk("R8 irq after clear", lock_irq, 0);

    // Drift into hysteresis band: count 66..67, lock held
    osc_half = 1.925;
    wins(3);
    chk("R4 lock held in band", lock, 1);
    chk("R7 no change no flag", lock_chg_flag, 0);

    // Divider change forces unlock
    expect_lock(0);
    syn_div = 6'd7;
    cycles(2);
    chk("R6 forced unlock", lock, 0);
    chk("R7 flag on fall", lock_chg_flag, 1);
    chk("R8 irq on fall", lock_irq, 1);
    clear_flag();
    wins(3);
    chk("R5 stays unlocked at count 83", lock, 0);

    // Same band from unlocked: must not acquire
    syn_div = 6'd9;
    wins(4);
    chk("R4 no acquire in band", lock, 0);
    chk("R7 flag quiet in band", lock_chg_flag, 0);

    // Back to exact match: acquire without divider change
    expect_lock(1);
    osc_half = 2.0;
    wins(3);
    chk("R3 reacquire", lock, 1);

    // Fast oscillator: count 80, lock lost
    expect_lock(0);
    osc_half = 1.6;
    wins(3);
    chk("R5 lock lost at count 80", lock, 0);
    chk("R7 flag after loss", lock_chg_flag, 1);
    clear_flag();
    lock_ie = 1'b0;

    // Slow reference: 80 ns ref, feedback 20*4 ns; windows of 512 cycles
    expect_lock(1);
    ref_div  = 4'd7;
    syn_div  = 6'd19;
    osc_half = 2.0;
    cycles(2 * 512 - 20);
    chk("R2 before second window end", lock, 0);
    cycles(40);
    chk("R2 after second window end", lock, 1);
    chk("R7 flag on slow lock", lock_chg_flag, 1);
    chk("R8 ie off masks irq", lock_irq, 0);

    cycles(4);
    chk("R3 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule